// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Reader

This block fetches a single 16-bit word from a small serial configuration EEPROM. The EEPROM sits on a three-wire link: a chip select, a serial clock, a command line toward the device and a data line back from it. The host presents a 6-bit word address and pulses `start`. The block then raises chip select, clocks out a 9-bit read command and clocks in 16 data bits. It releases the device with one closing clock pulse, and finally reports the word with a one-cycle `done` pulse.

The serial clock is slow, and its pace is set by `half_period`. Every high and every low phase of the serial clock lasts `half_period + 1` system clock cycles. At 50 MHz, a value of 1999 gives the 40 us spacing between transitions that such devices usually need. Only reads are issued. The word address space is 64 words, and words 2 to 4 typically carry a station address.

Top module: `mw_eeprom_reader`

## Requirements
- R1: The command is sent MSB first on `ee_di` as 9 bits: 1, 1, 0, then addr[5:0], so its value equals addr | 0x180. Each bit is stable while `ee_sk` is low before its rising edge and stays so through the high phase.
- R2: `ee_cs` rises on the clock edge that takes the start request. It stays high through exactly 25 `ee_sk` rising edges (9 command bits followed by 16 data bits).
- R3: Every high and low phase of `ee_sk` within a transaction lasts exactly `half_period + 1` cycles, counted from the `ee_cs` rise. `half_period` must be at least 2.
- R4: The 16 data bits are taken from `ee_do` MSB first. Each bit is sampled at the end of a high phase of `ee_sk`, and the device changes `ee_do` after a falling edge.
- R5: The transaction closes with `ee_cs` falling on the same edge as a final `ee_sk` rise. `ee_sk` stays high for one phase and then goes low, so exactly one pulse occurs with `ee_cs` low.
- R6: `done` is high for exactly one cycle, once the closing low phase has ended, and `busy` is low in that cycle. `rdata` then carries the word and changes only at the next `done`.
- R7: A `start` pulse while `busy` is high is ignored. The ongoing transaction is unchanged and no second transaction follows.
- R8: Out of reset and whenever idle, `ee_cs`, `ee_sk`, `ee_di`, `busy` and `done` are low. `busy` is high from the cycle after an accepted `start`.
- R9: `addr` and `half_period` are captured when `start` is accepted. Changing them during a transaction affects neither the command nor the timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start a read; taken only when idle |
| addr | input | ADDR_W | Word address |
| half_period | input | DIV_W | Serial clock phase length minus one, in clk cycles |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse: `rdata` holds the new word |
| rdata | output | DATA_W | Last word read |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Command bits toward the EEPROM |
| ee_do | input | 1 | Data bits from the EEPROM |

## Verification
A wrong bit index or a command register that shifts badly shows up at once in the 9-bit frame, which an EEPROM model captures at the pins. It also returns the wrong word about 50 phases later. A prescaler or phase-state fault shows up within one serial clock phase as a high or low run of the wrong length. An off-by-one in the data count shows up at the chip select fall as a wrong rising-edge count, or as a word shifted by one bit. A busy flag that does not lock out new requests shows up as an extra chip select rise or a corrupted command after a stray `start`.

// File: rtl/mwr_pkg.sv
package mwr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_LO      = 3'd1,
    ST_HI      = 3'd2,
    ST_TERM_HI = 3'd3,
    ST_TERM_LO = 3'd4
  } mwr_state_e;

  // start bit followed by the read opcode
  localparam logic [2:0] READ_PREFIX = 3'b110;

endpackage

// File: rtl/mwr_prescaler.sv
module mwr_prescaler #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             run,
  input  logic [DIV_W-1:0] limit,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
    end else if (run) begin
      if (cnt_q == limit) cnt_q <= '0;
      else                cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick = run && (cnt_q == limit);

endmodule

// File: rtl/mwr_sequencer.sv
module mwr_sequencer
  import mwr_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DIV_W-1:0]  half_period,
  input  logic              tick,
  output logic              run,
  output logic              clear,
  output logic              sample_en,
  output logic              finish,
  output logic [DIV_W-1:0]  limit,
  output logic              cs,
  output logic              sk,
  output logic              di,
  output logic              busy,
  output logic              done
);

  localparam int CMD_W = ADDR_W + 3;
  localparam int TOTAL = CMD_W + DATA_W;
  localparam int IDX_W = $clog2(TOTAL + 1);

  mwr_state_e        state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [CMD_W-1:0]  cmd_q, cmd_d;
  logic [DIV_W-1:0]  lim_q;
  logic              cs_q, sk_q, di_q, busy_q, done_q;
  logic              accept;

  assign accept = (state_q == ST_IDLE) && start;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    cmd_d   = cmd_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_LO;
          idx_d   = '0;
          cmd_d   = {READ_PREFIX, addr};
        end
      end
      ST_LO: begin
        if (tick) begin
          if (idx_q == IDX_W'(TOTAL)) state_d = ST_TERM_HI;
          else                        state_d = ST_HI;
        end
      end
      ST_HI: begin
        if (tick) begin
          state_d = ST_LO;
          idx_d   = idx_q + 1'b1;
          cmd_d   = {cmd_q[CMD_W-2:0], 1'b0};
        end
      end
      ST_TERM_HI: begin
        if (tick) state_d = ST_TERM_LO;
      end
      ST_TERM_LO: begin
        if (tick) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      cmd_q   <= '0;
      lim_q   <= '0;
      cs_q    <= 1'b0;
      sk_q    <= 1'b0;
      di_q    <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      cmd_q   <= cmd_d;
      if (accept) lim_q <= half_period;
      cs_q   <= (state_d == ST_LO) || (state_d == ST_HI);
      sk_q   <= (state_d == ST_HI) || (state_d == ST_TERM_HI);
      di_q   <= ((state_d == ST_LO) || (state_d == ST_HI)) &&
                (idx_d < IDX_W'(CMD_W)) && cmd_d[CMD_W-1];
      busy_q <= (state_d != ST_IDLE);
      done_q <= (state_q == ST_TERM_LO) && tick;
    end
  end

  assign run       = (state_q != ST_IDLE);
  assign clear     = accept;
  assign limit     = lim_q;
  assign sample_en = (state_q == ST_HI) && tick && (idx_q >= IDX_W'(CMD_W));
  assign finish    = (state_q == ST_TERM_LO) && tick;
  assign cs        = cs_q;
  assign sk        = sk_q;
  assign di        = di_q;
  assign busy      = busy_q;
  assign done      = done_q;

endmodule

// File: rtl/mwr_datapath.sv
module mwr_datapath #(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ee_do,
  input  logic              sample_en,
  input  logic              finish,
  output logic [DATA_W-1:0] rdata
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [DATA_W-1:0]      shift_q;
  logic [DATA_W-1:0]      word_q;

  generate
    if (SYNC_STAGES == 1) begin : g_sync_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= ee_do;
      end
    end else begin : g_sync_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], ee_do};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q <= '0;
      word_q  <= '0;
    end else begin
      if (sample_en) shift_q <= {shift_q[DATA_W-2:0], sync_q[SYNC_STAGES-1]};
      if (finish)    word_q  <= shift_q;
    end
  end

  assign rdata = word_q;

endmodule

// File: rtl/mw_eeprom_reader.sv
module mw_eeprom_reader #(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int DIV_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DIV_W-1:0]  half_period,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              ee_cs,
  output logic              ee_sk,
  output logic              ee_di,
  input  logic              ee_do
);

  logic             tick, run, clear, sample_en, finish;
  logic [DIV_W-1:0] limit;

  mwr_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk(clk), .rst(rst), .clear(clear), .run(run), .limit(limit), .tick(tick)
  );

  mwr_sequencer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W)) u_seq (
    .clk(clk), .rst(rst), .start(start), .addr(addr), .half_period(half_period),
    .tick(tick), .run(run), .clear(clear), .sample_en(sample_en), .finish(finish),
    .limit(limit), .cs(ee_cs), .sk(ee_sk), .di(ee_di), .busy(busy), .done(done)
  );

  mwr_datapath #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rst(rst), .ee_do(ee_do), .sample_en(sample_en),
    .finish(finish), .rdata(rdata)
  );

endmodule

// File: rtl/mwr_checker.sv
module mwr_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic [DATA_W-1:0] rdata,
  input logic              ee_cs,
  input logic              ee_sk,
  input logic              ee_di
);

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!ee_cs && !ee_sk && !ee_di));

  a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r6_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  a_r6_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !$stable(rdata) |-> done);

  a_r5_cs_drop_with_clock: assert property (@(posedge clk) disable iff (rst)
    $fell(ee_cs) |-> $rose(ee_sk));

  a_r3_clock_only_busy: assert property (@(posedge clk) disable iff (rst)
    !$stable(ee_sk) |-> busy);

  a_r2_cs_needs_busy: assert property (@(posedge clk) disable iff (rst)
    $rose(ee_cs) |-> (busy && !ee_sk));

endmodule

bind mw_eeprom_reader mwr_checker #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .rdata(rdata),
  .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di)
);

// File: tb/mw_eeprom_reader_tb_top.sv
module mw_eeprom_reader_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [5:0]  addr = '0;
  logic [15:0] half_period = 16'd3;
  logic        busy, done, ee_cs, ee_sk, ee_di;
  logic        ee_do = 1'b0;
  logic [15:0] rdata;

  always #10 clk = ~clk;

  mw_eeprom_reader dut_i (
    .clk(clk), .rst(rst), .start(start), .addr(addr), .half_period(half_period),
    .busy(busy), .done(done), .rdata(rdata), .ee_cs(ee_cs), .ee_sk(ee_sk),
    .ee_di(ee_di), .ee_do(ee_do)
  );

  int n_checks = 0;
  int n_fail   = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] word_of(input logic [5:0] a);
    if (a == 6'd5) return 16'hFFFF;
    if (a == 6'd6) return 16'h0000;
    return {~a[1:0], a, a ^ 6'h2A, a[5:4]};
  endfunction

  typedef struct { logic [5:0] a; logic [15:0] w; } exp_t;
  exp_t exp_q[$];

  // EEPROM model and pin-level protocol monitor
  logic        prev_sk = 1'b0, prev_cs = 1'b0;
  int          rise_cnt = 0, term_cnt = 0, run_len = 0, txn_starts = 0;
  int          active_p = 0;
  bit          in_txn = 1'b0;
  logic [8:0]  cmd_sh = '0;
  logic [15:0] out_sh = '0;

  always @(negedge clk) begin
    if (!rst) begin
      if (ee_cs && !prev_cs) begin
        txn_starts++;
        rise_cnt = 0; term_cnt = 0; cmd_sh = '0; in_txn = 1'b1;
        run_len = 1;
      end else if (ee_sk != prev_sk) begin
        if (in_txn) check(run_len == active_p, "R3 phase length", run_len, active_p);
        run_len = 1;
      end else begin
        run_len++;
      end
      if (prev_cs && !ee_cs) begin
        check(rise_cnt == 25, "R2 rising edges under cs", rise_cnt, 25);
        check(ee_sk && !prev_sk, "R5 cs falls with clock rise", ee_sk, 1);
      end
      if (ee_sk && !prev_sk) begin
        if (ee_cs) begin
          if (rise_cnt < 9) cmd_sh = {cmd_sh[7:0], ee_di};
          rise_cnt++;
        end else begin
          term_cnt++;
        end
      end
      if (!ee_sk && prev_sk) begin
        if (ee_cs && rise_cnt == 9) begin
          out_sh = word_of(cmd_sh[5:0]);
          ee_do  = out_sh[15];
        end else if (ee_cs && rise_cnt > 9) begin
          out_sh = {out_sh[14:0], 1'b0};
          ee_do  = out_sh[15];
        end else if (!ee_cs) begin
          in_txn = 1'b0;
        end
      end
      prev_sk = ee_sk;
      prev_cs = ee_cs;
    end
  end

  // scoreboard monitor
  int   done_seen = 0;
  bit   chk_done_low = 1'b0;
  exp_t cur;

  always @(negedge clk) begin
    if (chk_done_low) begin
      check(!done, "R6 done one cycle", done, 0);
      chk_done_low = 1'b0;
    end
    if (!rst && done) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 unexpected done", 1, 0);
      end else begin
        cur = exp_q.pop_front();
        check(rdata == cur.w, "R4 word returned", rdata, cur.w);
        check(cmd_sh == {3'b110, cur.a}, "R1 command frame", cmd_sh, {3'b110, cur.a});
        check(term_cnt == 1, "R5 closing pulse count", term_cnt, 1);
        check(!busy, "R6 busy low with done", busy, 0);
      end
      chk_done_low = 1'b1;
      done_seen++;
    end
  end

  task automatic issue(input logic [5:0] a, input logic [15:0] hp);
    exp_t e;
    while (busy) @(negedge clk);
    @(negedge clk);
    addr = a; half_period = hp; start = 1'b1;
    e.a = a; e.w = word_of(a);
    exp_q.push_back(e);
    active_p = int'(hp) + 1;
    @(negedge clk);
    start = 1'b0;
    check(busy, "R8 busy after start", busy, 1);
  endtask

  task automatic wait_done();
    int target = done_seen + 1;
    while (done_seen < target) @(negedge clk);
  endtask

  task automatic idle_check(input string tag);
    check(!ee_cs && !ee_sk && !ee_di && !busy && !done, tag,
          {ee_cs, ee_sk, ee_di, busy, done}, 0);
  endtask

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  logic [15:0] held;
  int          starts_before;

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    idle_check("R8 reset idle");
    check(rdata == 16'h0, "R6 reset rdata", rdata, 0);

    issue(6'd2, 16'd3); wait_done();
    issue(6'd3, 16'd3); wait_done();
    issue(6'd4, 16'd5); wait_done();
    issue(6'd0, 16'd2); wait_done();
    issue(6'd63, 16'd4); wait_done();
    issue(6'd5, 16'd3); wait_done();
    issue(6'd6, 16'd3); wait_done();
    @(negedge clk);
    idle_check("R8 idle between reads");

    // R6: word held after done and during the next read
    held = rdata;
    repeat (40) @(negedge clk);
    check(rdata == held, "R6 rdata held idle", rdata, held);
    issue(6'd21, 16'd3);
    repeat (60) @(negedge clk);
    check(rdata == held, "R6 rdata held during next read", rdata, held);
    wait_done();

    // R7: stray start while busy
    starts_before = txn_starts;
    issue(6'd10, 16'd3);
    repeat (30) @(negedge clk);
    addr = 6'd20; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    repeat (20) @(negedge clk);
    check(txn_starts == starts_before + 1, "R7 no extra transaction",
          txn_starts, starts_before + 1);
    idle_check("R7 idle after ignored start");

    // R9: inputs change mid-transaction
    issue(6'd12, 16'd3);
    addr = 6'd33; half_period = 16'd7;
    wait_done();
    check(exp_q.size() == 0, "R9 scoreboard drained", exp_q.size(), 0);

    repeat (5) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule